// File: doc/BRIEF.md
# Offset Physical Timer Comparator

This block presents a guest-adjusted view of a free-running 64-bit physical count and produces the guest physical timer interrupt from that view. A hypervisor-programmed offset can be subtracted from the raw count. When the offset is in force, reads of the count by the two lower privilege levels see the adjusted value. The timer comparison also uses the adjusted value. Reads by the two upper levels always see the raw count.

The offset is in force only when three conditions hold together. The feature enable must be set. The host-mode pair (E2H, TGE) must not both be 1. At least one of the non-secure bit and the secure-hypervisor enable bit must be 1. In every other case the block acts as a plain comparator on the raw count. The returned count and the status bit are combinational. The interrupt level passes through one register.

Top module: `opt_timer_top`

## Requirements
- R1: With offsetting active, a read with `req_lvl_i` equal to 0 or 1 returns `raw_cnt_i - offset_i`. Offsetting is active exactly when `feat_en_i` = 1, not (`e2h_i` = 1 and `tge_i` = 1), and (`ns_i` = 1 or `eel2_i` = 1).
- R2: A read with `req_lvl_i` equal to 2 or 3 returns `raw_cnt_i`, whatever the configuration.
- R3: With offsetting inactive, a read at any level returns `raw_cnt_i`.
- R4: With offsetting active, the timer condition is 1 exactly when bit 63 of `(raw_cnt_i - offset_i) - cval_i` is 0, which means the difference is non-negative as a signed value.
- R5: With offsetting inactive, the timer condition is 1 exactly when `raw_cnt_i >= cval_i` (unsigned).
- R6: All subtraction wraps modulo 2^64, including the case where the offset exceeds the raw count.
- R7: `irq_o` takes the value condition AND `tmr_en_i` AND NOT `tmr_mask_i` sampled at the previous rising clock edge.
- R8: `cond_o` reports the timer condition combinationally and does not depend on `tmr_en_i` or `tmr_mask_i`.
- R9: While `rst_ni` is low, `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raw_cnt_i | input | 64 | Raw physical count |
| offset_i | input | 64 | Hypervisor count offset |
| cval_i | input | 64 | Guest timer compare value |
| tmr_en_i | input | 1 | Timer enable |
| tmr_mask_i | input | 1 | Timer interrupt mask |
| req_lvl_i | input | 2 | Privilege level of the read, 0 to 3 |
| feat_en_i | input | 1 | Offset feature enable |
| e2h_i | input | 1 | Host-mode hypervisor bit |
| tge_i | input | 1 | Trap-general bit |
| ns_i | input | 1 | Non-secure state bit |
| eel2_i | input | 1 | Secure hypervisor enable bit |
| rd_cnt_o | output | 64 | Count value returned to the read |
| irq_o | output | 1 | Registered timer interrupt level |
| cond_o | output | 1 | Unmasked timer condition |

## Verification
The hardest cases to reach are those where the signed test on the offset difference and the unsigned raw comparison give different answers. One such case is a difference of exactly 2^63. Another is an offset larger than the raw count. In both, a comparator that used the wrong rule would still match on ordinary values. The stimulus fixes a small set of count, offset and compare triples built to land on these points and on the zero boundary. For each triple it sweeps all 32 configuration-bit combinations and all four levels. This exposes each wrong decode or wrong comparison rule at the ports.

// File: rtl/opt_pkg.sv
package opt_pkg;
  localparam int unsigned CNT_W = 64;

  typedef enum logic [1:0] {
    LVL_APP  = 2'd0,
    LVL_KERN = 2'd1,
    LVL_HYP  = 2'd2,
    LVL_MON  = 2'd3
  } lvl_e;

  function automatic logic is_guest(lvl_e l);
    return (l == LVL_APP) || (l == LVL_KERN);
  endfunction
endpackage

// File: rtl/opt_qualify.sv
module opt_qualify (
  input  logic feat_en_i,
  input  logic e2h_i,
  input  logic tge_i,
  input  logic ns_i,
  input  logic eel2_i,
  output logic off_active_o
);
  logic host_mode;
  logic sec_ok;

  always_comb begin
    host_mode    = e2h_i & tge_i;
    sec_ok       = ns_i | eel2_i;
    off_active_o = feat_en_i & ~host_mode & sec_ok;
  end
endmodule

// File: rtl/opt_cnt_view.sv
module opt_cnt_view
  import opt_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] off_i,
  input  lvl_e         lvl_i,
  input  logic         active_i,
  output logic [W-1:0] tmr_cnt_o,
  output logic [W-1:0] rd_cnt_o
);
  logic [W-1:0] adj;

  always_comb begin
    adj       = raw_i - off_i;
    tmr_cnt_o = active_i ? adj : raw_i;
    rd_cnt_o  = (active_i && is_guest(lvl_i)) ? adj : raw_i;
  end
endmodule

// File: rtl/opt_cmp.sv
module opt_cmp #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] tmr_cnt_i,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] cval_i,
  input  logic         active_i,
  output logic         cond_o
);
  logic [W-1:0] sdiff;
  logic [W:0]   udiff;

  always_comb begin
    sdiff  = tmr_cnt_i - cval_i;
    udiff  = {1'b0, raw_i} - {1'b0, cval_i};
    // active: signed sign of wrapped difference; inactive: unsigned borrow
    cond_o = active_i ? ~sdiff[W-1] : ~udiff[W];
  end
endmodule

// File: rtl/opt_timer_top.sv
module opt_timer_top
  import opt_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_cnt_i,
  input  logic [W-1:0] offset_i,
  input  logic [W-1:0] cval_i,
  input  logic         tmr_en_i,
  input  logic         tmr_mask_i,
  input  logic [1:0]   req_lvl_i,
  input  logic         feat_en_i,
  input  logic         e2h_i,
  input  logic         tge_i,
  input  logic         ns_i,
  input  logic         eel2_i,
  output logic [W-1:0] rd_cnt_o,
  output logic         irq_o,
  output logic         cond_o
);
  logic         off_active;
  logic [W-1:0] tmr_cnt;
  logic         irq_q;
  lvl_e         lvl;

  assign lvl = lvl_e'(req_lvl_i);

  opt_qualify u_qual (
    .feat_en_i   (feat_en_i),
    .e2h_i       (e2h_i),
    .tge_i       (tge_i),
    .ns_i        (ns_i),
    .eel2_i      (eel2_i),
    .off_active_o(off_active)
  );

  opt_cnt_view #(.W(W)) u_view (
    .raw_i    (raw_cnt_i),
    .off_i    (offset_i),
    .lvl_i    (lvl),
    .active_i (off_active),
    .tmr_cnt_o(tmr_cnt),
    .rd_cnt_o (rd_cnt_o)
  );

  opt_cmp #(.W(W)) u_cmp (
    .tmr_cnt_i(tmr_cnt),
    .raw_i    (raw_cnt_i),
    .cval_i   (cval_i),
    .active_i (off_active),
    .cond_o   (cond_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= cond_o & tmr_en_i & ~tmr_mask_i;
  end

  assign irq_o = irq_q;

  assert_guest_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_active && !req_lvl_i[1]) |-> (rd_cnt_o == raw_cnt_i - offset_i));

  assert_upper_raw_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_lvl_i[1] |-> (rd_cnt_o == raw_cnt_i));

  assert_inactive_raw_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !off_active |-> (rd_cnt_o == raw_cnt_i));

  assert_inactive_cmp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !off_active |-> (cond_o == (raw_cnt_i >= cval_i)));

  assert_irq_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(cond_o) && $past(tmr_en_i) && !$past(tmr_mask_i)));
endmodule

// File: tb/tb_opt_timer_top.sv
module tb_opt_timer_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] raw_cnt_i = '0, offset_i = '0, cval_i = '0;
  logic        tmr_en_i = 1'b0, tmr_mask_i = 1'b0;
  logic [1:0]  req_lvl_i = '0;
  logic        feat_en_i = 1'b0, e2h_i = 1'b0, tge_i = 1'b0, ns_i = 1'b0, eel2_i = 1'b0;
  logic [63:0] rd_cnt_o;
  logic        irq_o, cond_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  opt_timer_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_cnt_i(raw_cnt_i), .offset_i(offset_i),
    .cval_i(cval_i), .tmr_en_i(tmr_en_i), .tmr_mask_i(tmr_mask_i),
    .req_lvl_i(req_lvl_i), .feat_en_i(feat_en_i), .e2h_i(e2h_i), .tge_i(tge_i),
    .ns_i(ns_i), .eel2_i(eel2_i), .rd_cnt_o(rd_cnt_o), .irq_o(irq_o), .cond_o(cond_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_pat(int i);
    case (i)
      0: begin raw_cnt_i = 64'd1000; offset_i = 64'd0;   cval_i = 64'd500; end
      1: begin raw_cnt_i = 64'd1000; offset_i = 64'd200; cval_i = 64'd800; end
      2: begin raw_cnt_i = 64'd1000; offset_i = 64'd201; cval_i = 64'd800; end
      3: begin raw_cnt_i = 64'd5;    offset_i = 64'd10;  cval_i = 64'd0;   end
      4: begin raw_cnt_i = 64'h8000_0000_0000_0000; offset_i = '0; cval_i = '0; end
      5: begin raw_cnt_i = 64'h7FFF_FFFF_FFFF_FFFF; offset_i = '0; cval_i = '0; end
      6: begin raw_cnt_i = 64'd0;    offset_i = 64'd0;   cval_i = 64'd1;   end
      default: begin raw_cnt_i = 64'h10; offset_i = 64'hFFFF_FFFF_FFFF_FFF0; cval_i = 64'h18; end
    endcase
  endtask

  function automatic logic exp_active();
    return feat_en_i & ~(e2h_i & tge_i) & (ns_i | eel2_i);
  endfunction

  function automatic logic exp_cond();
    logic [63:0] d;
    d = raw_cnt_i - offset_i - cval_i;
    return exp_active() ? ~d[63] : (raw_cnt_i >= cval_i);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: reset holds irq low while condition, enable and no mask are present
    set_pat(0);
    tmr_en_i = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R9 irq in reset", {63'd0, irq_o}, 64'd0);
    rst_ni = 1'b1;
    tmr_en_i = 1'b0;

    // R1-R6 sweep: patterns x config bits x levels
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 32; c++) begin
        for (int l = 0; l < 4; l++) begin
          @(negedge clk_i);
          set_pat(p);
          {feat_en_i, e2h_i, tge_i, ns_i, eel2_i} = c[4:0];
          req_lvl_i = l[1:0];
          #1;
          if (l >= 2)
            chk("R2 upper-level read", rd_cnt_o, raw_cnt_i);
          else if (!exp_active())
            chk("R3 inactive read", rd_cnt_o, raw_cnt_i);
          else if (raw_cnt_i < offset_i)
            chk("R6 wrapped guest read", rd_cnt_o, raw_cnt_i - offset_i);
          else
            chk("R1 guest read", rd_cnt_o, raw_cnt_i - offset_i);
          if (exp_active())
            chk("R4 signed offset compare", {63'd0, cond_o}, {63'd0, exp_cond()});
          else
            chk("R5 raw unsigned compare", {63'd0, cond_o}, {63'd0, exp_cond()});
        end
      end
    end

    // R7/R8: irq register and mask independence of cond
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 4; c++) begin
        for (int m = 0; m < 4; m++) begin
          logic ec;
          @(negedge clk_i);
          set_pat(p);
          {feat_en_i, e2h_i, tge_i, ns_i, eel2_i} = {c[1], 1'b0, 1'b0, c[0], 1'b0};
          {tmr_en_i, tmr_mask_i} = m[1:0];
          req_lvl_i = 2'd0;
          #1;
          ec = exp_cond();
          chk("R8 cond ignores enable and mask", {63'd0, cond_o}, {63'd0, ec});
          @(negedge clk_i);
          chk("R7 registered irq", {63'd0, irq_o}, {63'd0, ec & tmr_en_i & ~tmr_mask_i});
        end
      end
    end

    // R9: asynchronous reset clears a set irq
    @(negedge clk_i);
    set_pat(0);
    feat_en_i = 1'b0;
    {tmr_en_i, tmr_mask_i} = 2'b10;
    @(negedge clk_i);
    chk("R7 irq set before reset", {63'd0, irq_o}, 64'd1);
    rst_ni = 1'b0;
    #1;
    chk("R9 irq cleared by reset", {63'd0, irq_o}, 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule